// File: doc/BRIEF.md
# Register Window Pointer Controller

This block tracks which window of an overlapping register-window file is current. It steps the window pointer down on a save, up on a restore, and up on a return-from-trap, which also re-enables traps. A per-window mask marks windows that may not be entered. When a step would land on a marked window, the step is refused and the block raises an overflow or underflow trap. The register storage, instruction decode and trap vectoring sit outside the block. Its outputs are a registered trap request with a two-bit code, the current window index for addressing the storage, and a pulse that tells the interrupt logic to re-evaluate.

The block also holds the processor status word. A write port loads every writable field, the window pointer included, and rejects any write that names a window beyond the configured count. A combinational read port packs the fields into one 32-bit word.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the window pointer is 0, the trap-enable bit is 0, supervisor is 1, previous-supervisor is 0, FP-enable is 0, PIL is 0, condition codes are 0, and `trap_req`, `trap_code` and `irq_recheck` are 0.
- R2: A window operation with `op_kind` = 0 (save) moves the pointer to pointer−1, and from 0 to NWIN−1.
- R3: A window operation with `op_kind` = 1 (restore) moves the pointer to pointer+1, and from NWIN−1 to 0.
- R4: If `win_mask` has a 1 at the target index, a save raises trap code 1 (overflow) and a restore raises trap code 2 (underflow). In both cases all status state stays unchanged.
- R5: `op_kind` = 2 (return-from-trap) with trap-enable already 1 raises code 3 (illegal) and changes nothing. Otherwise it targets pointer+1 with wrap. A masked target raises code 2 and changes nothing. An unmasked target moves the pointer, sets trap-enable to 1 and copies previous-supervisor into supervisor.
- R6: A status write with a legal window field loads every writable field, and `irq_recheck` is 1 for exactly the cycle after the write.
- R7: A status write whose bits 4:0 are NWIN or more raises code 3, changes no state and gives no `irq_recheck`.
- R8: `rd_data` is laid out as: 31:24 VERSION_ID, 23:20 condition codes, 19:13 zero, 12 FP-enable, 11:8 PIL, 7 supervisor, 6 previous-supervisor, 5 trap-enable, 4:0 window pointer. A write takes its fields from the same positions.
- R9: `trap_req` and `trap_code` are registered. They are valid in the cycle after the request and last one cycle. `trap_code` is 0 whenever `trap_req` is 0.
- R10: When `op_valid` and `wr_valid` are both 1, only the window operation acts and the write is dropped. `op_kind` = 3 has no effect, even when a write accompanies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Window operation strobe |
| op_kind | input | 2 | 0 save, 1 restore, 2 return-from-trap, 3 none |
| wr_valid | input | 1 | Status write strobe |
| wr_data | input | 32 | Status write word |
| win_mask | input | NWIN | One bit per window; 1 marks the window as not enterable |
| cur_win | output | 5 | Current window pointer |
| rd_data | output | 32 | Packed status word |
| trap_req | output | 1 | Trap request, one cycle |
| trap_code | output | 2 | 0 none, 1 overflow, 2 underflow, 3 illegal |
| irq_recheck | output | 1 | Interrupt re-evaluation pulse after a legal write |

## Verification
A window operation and a status write can arrive in the same cycle. The bench provokes this by strobing both, with write data that differs from the state the operation produces, and also pairs the inert `op_kind` 3 with a write. In each case it judges the outcome from the read word, the trap outputs and the absence of a re-evaluation pulse: only the operation's effect may appear, and the write must leave no trace.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
   localparam int unsigned PTR_W = 5;

   typedef enum logic [1:0] {
      OPK_SAVE    = 2'd0,
      OPK_RESTORE = 2'd1,
      OPK_RETT    = 2'd2,
      OPK_NONE    = 2'd3
   } op_kind_e;

   typedef enum logic [1:0] {
      TRC_NONE      = 2'd0,
      TRC_OVERFLOW  = 2'd1,
      TRC_UNDERFLOW = 2'd2,
      TRC_ILLEGAL   = 2'd3
   } trap_code_e;

   typedef struct packed {
      logic [3:0]       icc;
      logic             ef;
      logic [3:0]       pil;
      logic             s;
      logic             ps;
      logic             et;
      logic [PTR_W-1:0] cwp;
   } win_state_t;

   localparam win_state_t RESET_ST = '{icc: 4'd0, ef: 1'b0, pil: 4'd0, s: 1'b1,
                                       ps: 1'b0, et: 1'b0, cwp: 5'd0};
endpackage

// File: rtl/regwin_step.sv
// Neighbouring window indices with wrap; a power-of-two window count uses masking.
module regwin_step #(
   parameter int unsigned NWIN = 8
) (
   input  logic [4:0] cur,
   output logic [4:0] prev_win,
   output logic [4:0] next_win
);
   localparam logic [4:0] LAST = 5'(NWIN - 1);
   localparam bit         POW2 = ((NWIN & (NWIN - 1)) == 0);

   generate
      if (POW2) begin : g_mask
         assign prev_win = (cur - 5'd1) & LAST;
         assign next_win = (cur + 5'd1) & LAST;
      end else begin : g_cmp
         assign prev_win = (cur == 5'd0) ? LAST : cur - 5'd1;
         assign next_win = (cur == LAST) ? 5'd0 : cur + 5'd1;
      end
   endgenerate
endmodule

// File: rtl/regwin_probe.sv
// Looks up the mask bit of one window through a decoded select.
module regwin_probe #(
   parameter int unsigned NWIN = 8
) (
   input  logic [NWIN-1:0] mask,
   input  logic [4:0]      idx,
   output logic            hit
);
   logic [NWIN-1:0] sel;

   for (genvar i = 0; i < NWIN; i++) begin : g_sel
      assign sel[i] = (idx == 5'(i));
   end

   assign hit = |(mask & sel);
endmodule

// File: rtl/regwin_status.sv
// Packs the held state into the status word and decodes an incoming write.
module regwin_status
   import regwin_pkg::*;
#(
   parameter int unsigned NWIN       = 8,
   parameter logic [7:0]  VERSION_ID = 8'h5A
) (
   input  win_state_t  st,
   output logic [31:0] rd_word,
   input  logic [31:0] wr_word,
   output win_state_t  wr_fields,
   output logic        wr_legal
);
   localparam int unsigned ICC_LO = 20;
   localparam int unsigned EF_B   = 12;
   localparam int unsigned PIL_LO = 8;
   localparam int unsigned S_B    = 7;
   localparam int unsigned PS_B   = 6;
   localparam int unsigned ET_B   = 5;

   always_comb begin
      rd_word                   = '0;
      rd_word[31:24]            = VERSION_ID;
      rd_word[ICC_LO+3:ICC_LO]  = st.icc;
      rd_word[EF_B]             = st.ef;
      rd_word[PIL_LO+3:PIL_LO]  = st.pil;
      rd_word[S_B]              = st.s;
      rd_word[PS_B]             = st.ps;
      rd_word[ET_B]             = st.et;
      rd_word[PTR_W-1:0]        = st.cwp;
   end

   always_comb begin
      wr_fields.icc = wr_word[ICC_LO+3:ICC_LO];
      wr_fields.ef  = wr_word[EF_B];
      wr_fields.pil = wr_word[PIL_LO+3:PIL_LO];
      wr_fields.s   = wr_word[S_B];
      wr_fields.ps  = wr_word[PS_B];
      wr_fields.et  = wr_word[ET_B];
      wr_fields.cwp = wr_word[PTR_W-1:0];
   end

   assign wr_legal = ({1'b0, wr_word[PTR_W-1:0]} < 6'(NWIN));

   logic unused_wr_bits;
   assign unused_wr_bits = ^{wr_word[31:24], wr_word[19:13]};
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
   import regwin_pkg::*;
#(
   parameter int unsigned NWIN       = 8,
   parameter logic [7:0]  VERSION_ID = 8'h5A
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            op_valid,
   input  logic [1:0]      op_kind,
   input  logic            wr_valid,
   input  logic [31:0]     wr_data,
   input  logic [NWIN-1:0] win_mask,
   output logic [4:0]      cur_win,
   output logic [31:0]     rd_data,
   output logic            trap_req,
   output logic [1:0]      trap_code,
   output logic            irq_recheck
);
   if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
      $error("regwin_ctrl: NWIN must lie in 2..32");
   end

   win_state_t state_q, state_d, wr_fields;
   trap_code_e code_d;
   logic       recheck_d, wr_legal;
   logic [4:0] prev_win, next_win;
   logic       hit_prev, hit_next;

   regwin_step #(.NWIN(NWIN)) u_step (
      .cur(state_q.cwp), .prev_win(prev_win), .next_win(next_win));

   regwin_probe #(.NWIN(NWIN)) u_probe_prev (
      .mask(win_mask), .idx(prev_win), .hit(hit_prev));

   regwin_probe #(.NWIN(NWIN)) u_probe_next (
      .mask(win_mask), .idx(next_win), .hit(hit_next));

   regwin_status #(.NWIN(NWIN), .VERSION_ID(VERSION_ID)) u_status (
      .st(state_q), .rd_word(rd_data), .wr_word(wr_data),
      .wr_fields(wr_fields), .wr_legal(wr_legal));

   // A window operation outranks a status write arriving in the same cycle.
   always_comb begin
      state_d   = state_q;
      code_d    = TRC_NONE;
      recheck_d = 1'b0;
      if (op_valid) begin
         case (op_kind)
            OPK_SAVE: begin
               if (hit_prev) code_d = TRC_OVERFLOW;
               else          state_d.cwp = prev_win;
            end
            OPK_RESTORE: begin
               if (hit_next) code_d = TRC_UNDERFLOW;
               else          state_d.cwp = next_win;
            end
            OPK_RETT: begin
               if (state_q.et)    code_d = TRC_ILLEGAL;
               else if (hit_next) code_d = TRC_UNDERFLOW;
               else begin
                  state_d.cwp = next_win;
                  state_d.et  = 1'b1;
                  state_d.s   = state_q.ps;
               end
            end
            default: ;
         endcase
      end else if (wr_valid) begin
         if (!wr_legal) code_d = TRC_ILLEGAL;
         else begin
            state_d   = wr_fields;
            recheck_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= RESET_ST;
         trap_req    <= 1'b0;
         trap_code   <= TRC_NONE;
         irq_recheck <= 1'b0;
      end else begin
         state_q     <= state_d;
         trap_req    <= (code_d != TRC_NONE);
         trap_code   <= code_d;
         irq_recheck <= recheck_d;
      end
   end

   assign cur_win = state_q.cwp;
endmodule

// File: rtl/regwin_ctrl_chk.sv
module regwin_ctrl_chk
   import regwin_pkg::*;
#(
   parameter int unsigned NWIN = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic        op_valid,
   input logic [1:0]  op_kind,
   input logic        wr_valid,
   input logic [31:0] wr_data,
   input logic [4:0]  cur_win,
   input logic [31:0] rd_data,
   input logic        trap_req,
   input logic [1:0]  trap_code,
   input logic        irq_recheck
);
   logic unused_chk;
   assign unused_chk = ^wr_data[31:5];

   assert_ptr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cur_win) < NWIN);

   assert_save_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_kind) == OPK_SAVE && !trap_req) |->
      (cur_win == (($past(cur_win) == 5'd0) ? 5'(NWIN - 1) : $past(cur_win) - 5'd1)));

   assert_restore_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_kind) == OPK_RESTORE && !trap_req) |->
      (cur_win == (($past(cur_win) == 5'(NWIN - 1)) ? 5'd0 : $past(cur_win) + 5'd1)));

   assert_trap_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (rd_data == $past(rd_data)));

   assert_rett_et_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(op_valid) && $past(op_kind) == OPK_RETT && $past(rd_data[5])) |->
      (trap_req && trap_code == TRC_ILLEGAL));

   assert_recheck_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_recheck |-> (!trap_req && $past(wr_valid) && !$past(op_valid)));

   assert_bad_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr_valid) && !$past(op_valid) && 32'($past(wr_data[4:0])) >= NWIN) |->
      (trap_code == TRC_ILLEGAL && !irq_recheck));

   assert_code_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_req |-> (trap_code == TRC_NONE));

   assert_trap_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> ($past(op_valid) || $past(wr_valid)));
endmodule

bind regwin_ctrl regwin_ctrl_chk #(.NWIN(NWIN)) u_regwin_chk (.*);

// File: tb/test_regwin_ctrl.sv
module test_regwin_ctrl;
   localparam int unsigned NW = 8;
   localparam logic [7:0]  VER = 8'h5A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          op_valid = 1'b0;
   logic [1:0]    op_kind = 2'd3;
   logic          wr_valid = 1'b0;
   logic [31:0]   wr_data = '0;
   logic [NW-1:0] win_mask = '0;
   logic [4:0]    cur_win;
   logic [31:0]   rd_data;
   logic          trap_req;
   logic [1:0]    trap_code;
   logic          irq_recheck;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int       m_cwp;
   bit       m_et, m_s, m_ps, m_ef;
   bit [3:0] m_pil, m_icc;

   always #10 clk = ~clk;

   regwin_ctrl #(.NWIN(NW), .VERSION_ID(VER)) i_regwin_ctrl (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
      .wr_valid(wr_valid), .wr_data(wr_data), .win_mask(win_mask),
      .cur_win(cur_win), .rd_data(rd_data), .trap_req(trap_req),
      .trap_code(trap_code), .irq_recheck(irq_recheck));

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(int c, bit et, bit ps, bit s, bit [3:0] pil,
                                      bit ef, bit [3:0] icc);
      return {8'h00, icc, 7'b0, ef, pil, s, ps, et, 5'(c)};
   endfunction

   function automatic logic [31:0] exp_rd();
      return {VER, m_icc, 7'b0, m_ef, m_pil, m_s, m_ps, m_et, 5'(m_cwp)};
   endfunction

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // One request cycle; expected results come from the requirement text.
   task automatic step(string req, bit ov, bit [1:0] kind, bit wv, logic [31:0] wd,
                       logic [NW-1:0] wim);
      int ec = 0;
      bit erc = 1'b0;
      int t;
      if (ov) begin
         case (kind)
            2'd0: begin t = (m_cwp + NW - 1) % NW; if (wim[t]) ec = 1; else m_cwp = t; end
            2'd1: begin t = (m_cwp + 1) % NW; if (wim[t]) ec = 2; else m_cwp = t; end
            2'd2: begin
               t = (m_cwp + 1) % NW;
               if (m_et) ec = 3;
               else if (wim[t]) ec = 2;
               else begin m_cwp = t; m_et = 1'b1; m_s = m_ps; end
            end
            default: ;
         endcase
      end else if (wv) begin
         if (int'(wd[4:0]) >= NW) ec = 3;
         else begin
            m_cwp = int'(wd[4:0]); m_et = wd[5]; m_ps = wd[6]; m_s = wd[7];
            m_pil = wd[11:8]; m_ef = wd[12]; m_icc = wd[23:20];
            erc = 1'b1;
         end
      end
      @(negedge clk);
      op_valid = ov; op_kind = kind; wr_valid = wv; wr_data = wd; win_mask = wim;
      @(negedge clk);
      op_valid = 1'b0; op_kind = 2'd3; wr_valid = 1'b0;
      chk(req, "trap_req", 32'(trap_req), 32'(ec != 0));
      chk(req, "trap_code", 32'(trap_code), 32'(ec));
      chk(req, "irq_recheck", 32'(irq_recheck), 32'(erc));
      chk(req, "rd_data", rd_data, exp_rd());
      chk(req, "cur_win", 32'(cur_win), 32'(m_cwp));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      m_cwp = 0; m_et = 0; m_s = 1; m_ps = 0; m_ef = 0; m_pil = 0; m_icc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "rd_data", rd_data, 32'h5A00_0080);
      chk("R1", "trap_req", 32'(trap_req), 0);
      chk("R1", "irq_recheck", 32'(irq_recheck), 0);
      chk("R1", "cur_win", 32'(cur_win), 0);

      // R2, R3, R4: every start window, every single-window mask and no mask
      for (int st = 0; st < NW; st++) begin
         for (int w = -1; w < int'(NW); w++) begin
            for (int k = 0; k < 2; k++) begin
               logic [NW-1:0] wim;
               int tgt;
               string tag;
               wim = (w < 0) ? '0 : (NW'(1) << w);
               tgt = (k == 0) ? (st + NW - 1) % NW : (st + 1) % NW;
               step("R6 R8", 1'b0, 2'd3, 1'b1,
                    mk(st, 1'b0, 1'b1, 1'b0, 4'(st), st[0], ~4'(st)), '0);
               if (w == tgt) tag = "R4";
               else tag = (k == 0) ? "R2" : "R3";
               step(tag, 1'b1, 2'(k), 1'b0, '0, wim);
            end
         end
      end

      // R5: return-from-trap in its three outcomes
      for (int st = 0; st < NW; st++) begin
         step("R6", 1'b0, 2'd3, 1'b1, mk(st, 1'b1, 1'b0, 1'b1, 4'd3, 1'b0, 4'd5), '0);
         step("R5 illegal", 1'b1, 2'd2, 1'b0, '0, '0);
         step("R6", 1'b0, 2'd3, 1'b1, mk(st, 1'b0, st[0], ~st[0], 4'd9, 1'b1, 4'd2), '0);
         step("R5 underflow", 1'b1, 2'd2, 1'b0, '0, NW'(1) << ((st + 1) % NW));
         step("R5 enter", 1'b1, 2'd2, 1'b0, '0, NW'(1) << st);
      end

      // R7: window field out of range
      step("R6", 1'b0, 2'd3, 1'b1, mk(3, 1'b0, 1'b1, 1'b0, 4'hA, 1'b1, 4'hC), '0);
      for (int c = NW; c < 32; c++) begin
         step("R7", 1'b0, 2'd3, 1'b1, mk(c, 1'b1, 1'b0, 1'b1, 4'h1, 1'b0, 4'h3), '0);
      end

      // R9: a trap lasts one cycle
      step("R9", 1'b1, 2'd1, 1'b0, '0, NW'(1) << 4);
      @(negedge clk);
      chk("R9", "trap_req next", 32'(trap_req), 0);
      chk("R9", "trap_code next", 32'(trap_code), 0);

      // R10: operation and write in one cycle; inert operation kind
      step("R10 op+write", 1'b1, 2'd0, 1'b1, mk(6, 1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 4'hF), '0);
      step("R10 op+write", 1'b1, 2'd1, 1'b1, mk(1, 1'b0, 1'b0, 1'b0, 4'h0, 1'b1, 4'h7), '0);
      step("R10 none", 1'b1, 2'd3, 1'b0, '0, '1);
      step("R10 none+write", 1'b1, 2'd3, 1'b1, mk(0, 1'b1, 1'b1, 1'b1, 4'h4, 1'b1, 4'h4), '0);
      step("R10 save+bad write", 1'b1, 2'd0, 1'b1, mk(31, 1'b0, 1'b0, 1'b0, 4'h0, 1'b0, 4'h0), '0);

      report();
   end
endmodule